// File: doc/BRIEF.md
# Asynchronous Serial Port with Enable-Controlled Pins and Flags

This block is a UART transmitter and receiver behind a small register set. The control register selects the clock source, enables the transmitter and the receiver, and enables three level interrupts. A format register selects a 7- or 8-bit data length, optional even or odd parity, and one or two stop bits. A divisor sets the internal oversampling tick. Software writes a byte to the transmit data register. The byte moves into a shift register as soon as the shifter is free. Received bytes land in a receive data register, and sticky flags report its state.

The design centres on what the two enable bits do. Clearing transmit-enable aborts the frame on the line, resets the shifter, forces the transmit-empty flag high and releases the output pin. Clearing receive-enable stops sampling of the input pin but leaves the received byte and every receive flag as they were. Software clears a flag by reading it as 1 from the status register and then writing 0 to that bit. A clock-output selection drives a bit-rate clock on its pin as soon as the control register is written, whatever the enables are.

Top module: `sio_async_port`

## Requirements
- R1: After reset the status register (address 5) reads 0x01: transmit-empty (bit 0) is set, and receive-full (bit 1), parity error (bit 2), framing error (bit 3) and overrun (bit 4) are clear. After reset `sout_oe`, `sclk_oe` and all interrupt outputs are 0 and `sout` is 1.
- R2: A transmitted frame has these bits in order:
  - a 0 start bit;
  - the data bits, LSB first, 8 of them or 7 when format bit 0 is set;
  - a parity bit when format bit 1 is set, even parity by default and odd when format bit 2 is set;
  - one stop bit of value 1, or two when format bit 3 is set.

  Each bit lasts 16 ticks. With the internal clock, one tick is divisor+1 clock cycles.
- R3: A write to the transmit data register (address 3) while the transmitter is enabled clears transmit-empty. The flag is set again when the byte moves into the shift register, so a second byte written during a frame keeps the flag clear until that frame ends.
- R4: Clearing transmit-enable (control bit 0) aborts any frame in progress and sets transmit-empty. While the transmitter is disabled, writes to the transmit data register are ignored, and no frame goes out when it is enabled again.
- R5: `sout_oe` is 1 exactly while transmit-enable is set, with `sout` at 1 otherwise. The input pin is ignored while receive-enable (control bit 1) is 0: a frame sent in that time sets no flag and leaves the receive data register unchanged.
- R6: The receiver looks for a start bit at a falling edge of the input, and checks it again 8 ticks later. A low pulse that has ended by then is discarded and the search restarts. After a valid start bit, each following bit is sampled every 16 ticks and the data is placed in the receive data register (address 4) with receive-full set.
- R7: When the first stop bit is sampled as 0, the framing error flag is set. When parity is enabled and the received parity bit does not match, the parity error flag is set.
- R8: When a frame completes while receive-full is still set, the overrun flag is set and the receive data register keeps its old byte.
- R9: Clearing receive-enable leaves the receive data register and the receive-full, parity, framing and overrun flags unchanged.
- R10: Writing 0 to a receive flag clears it only if the status register was read while that flag was 1. Without that read, the write has no effect.
- R11: When control bits 6:5 are written as 01, `sclk_oe` becomes 1 on the next cycle and `sclk_o` toggles once every 8 ticks, even with both enables at 0.
- R12: When control bit 6 is set, ticks come from rising edges on `ext_clk` and the divisor has no effect.
- R13: `irq_tx` is transmit-empty gated by control bit 2. `irq_rx` is receive-full gated by control bit 3. `irq_err` is the OR of the three error flags gated by control bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address: 0 control, 1 format, 2 divisor, 3 transmit data, 4 receive data, 5 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_clk | input | 1 | External oversampling clock, 16 rising edges per bit |
| sin | input | 1 | Serial input |
| sout | output | 1 | Serial output |
| sout_oe | output | 1 | Drive enable for `sout` |
| sclk_o | output | 1 | Bit-rate clock output |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive error interrupt |

## Verification
The assertions check on every cycle that a disabled transmitter holds the line released with transmit-empty set. They also check that the receiver reports no completion while disabled, and that a disabled receiver keeps its byte and flags. Further checks cover the overrun case keeping the old byte, the clock output appearing right after the control write, and a transmit data write clearing the empty flag. Frame contents and bit timing cannot be checked by these properties, and neither can false-start rejection, the read-then-write clearing sequence, or the divisor being ignored under the external clock. The bench's scenarios show these by decoding and driving whole frames.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_FMT  = 3'd1,
        REG_DIV  = 3'd2,
        REG_TXD  = 3'd3,
        REG_RXD  = 3'd4,
        REG_STAT = 3'd5
    } reg_addr_e;

    localparam logic [1:0] CKS_INT_OUT = 2'b01;

    localparam int ST_TXE = 0;
    localparam int ST_RXF = 1;
    localparam int ST_PER = 2;
    localparam int ST_FER = 3;
    localparam int ST_OVR = 4;
    localparam int NFLAG  = 5;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       err_ie;
        logic       rx_ie;
        logic       tx_ie;
        logic       rx_en;
        logic       tx_en;
    } ctrl_t;

    typedef struct packed {
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic len7;
    } fmt_t;

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_sel,
    input  logic             ext_clk,
    output logic             tick,
    output logic             bclk
);
    localparam int PW = $clog2(OVS);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [2:0]       sync;
        logic [PW-1:0]    phase;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[1:0], ext_clk};
        if (ext_sel) tick = s_q.sync[1] & ~s_q.sync[2];
        else         tick = (s_q.cnt == div);
        s_d.cnt = (ext_sel || tick) ? '0 : s_q.cnt + 1'b1;
        if (tick) s_d.phase = s_q.phase + 1'b1;
    end

    assign bclk = s_q.phase[PW-1];

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  fmt_t       fmt,
    input  logic [7:0] data,
    input  logic       load,
    output logic       take,
    output logic       line
);
    localparam int PW = $clog2(OVS);
    localparam int FW = 12;

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] tcnt;
        logic [3:0]    left;
        logic [FW-1:0] shreg;
    } st_t;

    st_t s_q, s_d;
    logic [FW-1:0] frame;
    logic [3:0]    nbits;
    int            dlen;

    always_comb begin
        dlen     = fmt.len7 ? 7 : 8;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < dlen) frame[i+1] = data[i];
        end
        if (fmt.par_en)
            frame[dlen+1] = ^(fmt.len7 ? {1'b0, data[6:0]} : data) ^ fmt.par_odd;
        nbits = 4'(1 + dlen + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 2 : 1));

        s_d  = s_q;
        take = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (!s_q.busy) begin
            if (load) begin
                take      = 1'b1;
                s_d.busy  = 1'b1;
                s_d.shreg = frame;
                s_d.left  = nbits;
                s_d.tcnt  = '0;
            end
        end else if (tick) begin
            s_d.tcnt = s_q.tcnt + 1'b1;
            if (s_q.tcnt == PW'(OVS-1)) begin
                if (s_q.left == 4'd1) s_d.busy = 1'b0;
                s_d.shreg = {1'b1, s_q.shreg[FW-1:1]};
                s_d.left  = s_q.left - 1'b1;
            end
        end
    end

    assign line = s_q.busy ? s_q.shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       len7,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       sin,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    localparam int PW = $clog2(OVS);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

    typedef struct packed {
        rx_st_e        st;
        logic [1:0]    sync;
        logic          prev;
        logic [PW-1:0] tcnt;
        logic [3:0]    bitn;
        logic [9:0]    shreg;
        logic          done;
        logic [7:0]    data;
        logic          perr;
        logic          ferr;
    } st_t;

    st_t s_q, s_d;
    logic       smp;
    logic [7:0] dat;
    logic [3:0] dlen;
    logic [3:0] nlast;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = en ? {s_q.sync[0], sin} : 2'b11;
        smp      = s_q.sync[1];
        dlen     = len7 ? 4'd7 : 4'd8;
        nlast    = dlen + {3'b0, par_en};
        dat      = len7 ? {1'b0, s_q.shreg[6:0]} : s_q.shreg[7:0];
        if (!en) begin
            s_d.st   = RX_IDLE;
            s_d.prev = 1'b1;
            s_d.tcnt = '0;
            s_d.bitn = '0;
        end else if (tick) begin
            case (s_q.st)
                RX_IDLE: begin
                    if (s_q.prev && !smp) begin
                        s_d.st   = RX_START;
                        s_d.tcnt = '0;
                    end
                    s_d.prev = smp;
                end
                RX_START: begin
                    if (s_q.tcnt == PW'(OVS/2-1)) begin
                        if (smp) begin
                            s_d.st   = RX_IDLE;
                            s_d.prev = 1'b1;
                        end else begin
                            s_d.st   = RX_BITS;
                            s_d.tcnt = '0;
                            s_d.bitn = '0;
                        end
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
                default: begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == PW'(OVS-1)) begin
                        if (s_q.bitn == nlast) begin
                            s_d.done = 1'b1;
                            s_d.data = dat;
                            s_d.perr = par_en & (s_q.shreg[dlen] ^ (^dat) ^ par_odd);
                            s_d.ferr = ~smp;
                            s_d.st   = RX_IDLE;
                            s_d.prev = smp;
                        end else begin
                            s_d.shreg[s_q.bitn] = smp;
                            s_d.bitn = s_q.bitn + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign done = s_q.done;
    assign data = s_q.data;
    assign perr = s_q.perr;
    assign ferr = s_q.ferr;

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{st: RX_IDLE, sync: 2'b11, prev: 1'b1, default: '0};
        else     s_q <= s_d;
    end
endmodule

// File: rtl/sio_async_port.sv
module sio_async_port
    import sio_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_clk,
    input  logic       sin,
    output logic       sout,
    output logic       sout_oe,
    output logic       sclk_o,
    output logic       sclk_oe,
    output logic       irq_tx,
    output logic       irq_rx,
    output logic       irq_err
);
    typedef struct packed {
        ctrl_t            ctrl;
        fmt_t             fmt;
        logic [DIV_W-1:0] div;
        logic [7:0]       txd;
        logic [NFLAG-1:0] flags;
        logic [7:0]       rxd;
        logic [NFLAG-2:0] armed;
    } regs_t;

    regs_t r_q, r_d;

    logic tick, bclk, tx_take, tx_line;
    logic rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_data;
    logic tx_en, rx_en;
    logic [NFLAG-1:0] flags;
    logic [7:0] rxd_val;

    assign tx_en   = r_q.ctrl.tx_en;
    assign rx_en   = r_q.ctrl.rx_en;
    assign flags   = r_q.flags;
    assign rxd_val = r_q.rxd;

    sio_baud #(.DIV_W(DIV_W), .OVS(OVS)) i_baud (
        .clk(clk), .rst(rst), .div(r_q.div), .ext_sel(r_q.ctrl.clk_sel[1]),
        .ext_clk(ext_clk), .tick(tick), .bclk(bclk)
    );

    sio_tx #(.OVS(OVS)) i_tx (
        .clk(clk), .rst(rst), .en(tx_en), .tick(tick), .fmt(r_q.fmt),
        .data(r_q.txd), .load(~r_q.flags[ST_TXE]), .take(tx_take), .line(tx_line)
    );

    sio_rx #(.OVS(OVS)) i_rx (
        .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .len7(r_q.fmt.len7),
        .par_en(r_q.fmt.par_en), .par_odd(r_q.fmt.par_odd), .sin(sin),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            REG_CTRL: bus_rdata = 8'(r_q.ctrl);
            REG_FMT:  bus_rdata = 8'(r_q.fmt);
            REG_DIV:  bus_rdata = 8'(r_q.div);
            REG_TXD:  bus_rdata = r_q.txd;
            REG_RXD:  bus_rdata = r_q.rxd;
            REG_STAT: bus_rdata = 8'(r_q.flags);
            default:  bus_rdata = 8'h00;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (tx_take) r_d.flags[ST_TXE] = 1'b1;
        if (bus_rd && bus_addr == REG_STAT)
            r_d.armed = r_q.armed | r_q.flags[NFLAG-1:1];
        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                REG_CTRL: r_d.ctrl = ctrl_t'(bus_wdata[6:0]);
                REG_FMT:  r_d.fmt  = fmt_t'(bus_wdata[3:0]);
                REG_DIV:  r_d.div  = DIV_W'(bus_wdata);
                REG_TXD: begin
                    if (tx_en) begin
                        r_d.txd            = bus_wdata;
                        r_d.flags[ST_TXE] = 1'b0;
                    end
                end
                REG_STAT: begin
                    for (int i = 1; i < NFLAG; i++) begin
                        if (r_q.armed[i-1] && !bus_wdata[i]) begin
                            r_d.flags[i]   = 1'b0;
                            r_d.armed[i-1] = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (rx_done) begin
            if (r_q.flags[ST_RXF]) begin
                r_d.flags[ST_OVR] = 1'b1;
            end else begin
                r_d.rxd           = rx_data;
                r_d.flags[ST_RXF] = 1'b1;
                if (rx_perr) r_d.flags[ST_PER] = 1'b1;
                if (rx_ferr) r_d.flags[ST_FER] = 1'b1;
            end
        end
        if (!tx_en) r_d.flags[ST_TXE] = 1'b1;
    end

    assign sout    = tx_en ? tx_line : 1'b1;
    assign sout_oe = tx_en;
    assign sclk_oe = (r_q.ctrl.clk_sel == CKS_INT_OUT);
    assign sclk_o  = bclk;
    assign irq_tx  = r_q.ctrl.tx_ie & r_q.flags[ST_TXE];
    assign irq_rx  = r_q.ctrl.rx_ie & r_q.flags[ST_RXF];
    assign irq_err = r_q.ctrl.err_ie & (|r_q.flags[ST_OVR:ST_PER]);

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{flags: NFLAG'(1) << ST_TXE, default: '0};
        else     r_q <= r_d;
    end
endmodule

// File: rtl/sio_async_port_chk.sv
module sio_async_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       rx_en,
    input logic [4:0] flags,
    input logic [7:0] rxd,
    input logic       sout,
    input logic       sout_oe,
    input logic       sclk_oe,
    input logic       rx_done,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [1:0] wdata_cks
);
    // R4
    tx_off_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!tx_en) |-> flags[0]);

    // R4
    tx_off_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (sout && !sout_oe));

    // R3
    txd_write_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == 3'd3 && tx_en) |-> !flags[0]);

    // R5
    rx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && $past(!rx_en)) |-> !rx_done);

    // R9
    rx_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rx_en && !rx_done && !(bus_wr && bus_addr == 3'd5))
        |-> ($stable(rxd) && $stable(flags[4:1])));

    // R8
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && flags[1]) |=> (flags[4] && $stable(rxd)));

    // R11
    clk_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == 3'd0 && wdata_cks == 2'b01) |-> sclk_oe);
endmodule

bind sio_async_port sio_async_port_chk i_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .flags(flags),
    .rxd(rxd_val), .sout(sout), .sout_oe(sout_oe), .sclk_oe(sclk_oe),
    .rx_done(rx_done), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wdata_cks(bus_wdata[6:5])
);

// File: tb/test_sio_async_port.sv
module test_sio_async_port;
    localparam int BIT = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic ext_clk = 1'b0;
    logic ext_run = 1'b0;
    logic sin = 1'b1;
    logic sout, sout_oe, sclk_o, sclk_oe, irq_tx, irq_rx, irq_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    sio_async_port i_sio_async_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .sin(sin),
        .sout(sout), .sout_oe(sout_oe), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                ph = (ph == 5) ? 0 : ph + 1;
                ext_clk = (ph < 3);
            end else begin
                ext_clk = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        rd(3'd5, d);
        wr(3'd5, 8'h00);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int dlen, input bit pen,
                        input bit pbit, input bit stopv);
        @(negedge clk); sin = 1'b0; idle(BIT);
        for (int i = 0; i < dlen; i++) begin sin = d[i]; idle(BIT); end
        if (pen) begin sin = pbit; idle(BIT); end
        sin = stopv; idle(BIT);
        sin = 1'b1; idle(40);
    endtask

    task automatic tx_expect(input logic [7:0] d, input int dlen, input bit pen,
                             input bit podd, input int nstop, input string req);
        logic [11:0] ev, gv, m;
        int nb, to;
        ev = '1; ev[0] = 1'b0;
        for (int i = 0; i < dlen; i++) ev[i+1] = d[i];
        if (pen) ev[dlen+1] = (^(d & 8'((1 << dlen) - 1))) ^ podd;
        nb = 1 + dlen + (pen ? 1 : 0) + nstop;
        m  = 12'((1 << nb) - 1);
        to = 0;
        while (sout !== 1'b0 && to < 3000) begin @(negedge clk); to++; end
        gv = '1;
        idle(BIT/2);
        gv[0] = sout;
        for (int i = 1; i < nb; i++) begin idle(BIT); gv[i] = sout; end
        check(req, "transmitted frame bits", int'(gv & m), int'(ev & m));
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd5, d);
        check("R1", "status after reset", d, 8'h01);
        check("R1", "sout_oe/sout/sclk_oe after reset", {sout_oe, sout, sclk_oe}, 3'b010);
        check("R1", "interrupts after reset", {irq_tx, irq_rx, irq_err}, 3'b000);
    endtask

    task automatic t_tx_basic();
        logic [7:0] d;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        check("R5", "sout_oe with transmitter on", sout_oe, 1);
        wr(3'd3, 8'hA5);
        wr(3'd3, 8'h5A);
        rd(3'd5, d);
        check("R3", "tx empty with a byte pending", d[0], 0);
        tx_expect(8'hA5, 8, 1'b0, 1'b0, 1, "R2");
        tx_expect(8'h5A, 8, 1'b0, 1'b0, 1, "R3");
        idle(40);
        rd(3'd5, d);
        check("R3", "tx empty after last frame", d[0], 1);
    endtask

    task automatic t_tx_format();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h0B);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h55);
        tx_expect(8'h55, 7, 1'b1, 1'b0, 2, "R2");
        idle(80);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h06);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h03);
        tx_expect(8'h03, 8, 1'b1, 1'b1, 1, "R2");
        idle(60);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_tx_abort();
        logic [7:0] d;
        int lows;
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h00);
        idle(100);
        wr(3'd0, 8'h00);
        check("R4", "line released on disable", {sout_oe, sout}, 2'b01);
        rd(3'd5, d);
        check("R4", "tx empty after disable", d[0], 1);
        wr(3'd3, 8'h12);
        rd(3'd5, d);
        check("R4", "tx empty after write while disabled", d[0], 1);
        wr(3'd0, 8'h01);
        lows = 0;
        for (int i = 0; i < 400; i++) begin @(negedge clk); if (sout == 1'b0) lows++; end
        check("R4", "low samples after re-enable", lows, 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_rx_basic();
        logic [7:0] d;
        wr(3'd0, 8'h02);
        send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd5, d);
        check("R6", "status after frame", d, 8'h03);
        rd(3'd4, d);
        check("R6", "received byte", d, 8'h3C);
        wr(3'd5, 8'h00);
        rd(3'd5, d);
        check("R10", "status after read-then-clear", d, 8'h01);
    endtask

    task automatic t_clear_protocol();
        logic [7:0] d;
        send(8'h44, 8, 1'b0, 1'b0, 1'b1);
        wr(3'd5, 8'h00);
        rd(3'd5, d);
        check("R10", "clear without prior read", d, 8'h03);
        wr(3'd5, 8'h00);
        rd(3'd5, d);
        check("R10", "clear after read", d, 8'h01);
    endtask

    task automatic t_false_start();
        logic [7:0] d;
        @(negedge clk); sin = 1'b0; idle(6); sin = 1'b1; idle(600);
        rd(3'd5, d);
        check("R6", "status after short low pulse", d, 8'h01);
        send(8'h81, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd4, d);
        check("R6", "byte after rejected start", d, 8'h81);
        clear_flags();
    endtask

    task automatic t_rx_ignored();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        send(8'h77, 8, 1'b0, 1'b0, 1'b1);
        wr(3'd0, 8'h02);
        idle(100);
        rd(3'd5, d);
        check("R5", "status after frame while disabled", d, 8'h01);
        rd(3'd4, d);
        check("R5", "data register after frame while disabled", d, 8'h81);
    endtask

    task automatic t_rx_errors();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h06);
        wr(3'd0, 8'h02);
        send(8'h3C, 8, 1'b1, 1'b0, 1'b1);
        rd(3'd5, d);
        check("R7", "status with wrong odd parity", d, 8'h07);
        wr(3'd5, 8'h00);
        send(8'h3C, 8, 1'b1, 1'b1, 1'b1);
        rd(3'd5, d);
        check("R7", "status with correct odd parity", d, 8'h03);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h02);
        send(8'h5A, 8, 1'b0, 1'b0, 1'b0);
        rd(3'd5, d);
        check("R7", "status with low stop bit", d, 8'h0B);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_overrun_and_disable();
        logic [7:0] d;
        send(8'h11, 8, 1'b0, 1'b0, 1'b1);
        send(8'h22, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd5, d);
        check("R8", "status after overrun", d, 8'h13);
        rd(3'd4, d);
        check("R8", "data kept on overrun", d, 8'h11);
        wr(3'd0, 8'h00);
        idle(20);
        rd(3'd5, d);
        check("R9", "status after receiver disable", d, 8'h13);
        rd(3'd4, d);
        check("R9", "data after receiver disable", d, 8'h11);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_irq();
        wr(3'd0, 8'h05);
        check("R13", "irq_tx with empty and enable", irq_tx, 1);
        wr(3'd0, 8'h0A);
        check("R13", "irq_tx and irq_rx before frame", {irq_tx, irq_rx}, 2'b00);
        send(8'h66, 8, 1'b0, 1'b0, 1'b1);
        check("R13", "irq_rx after frame", irq_rx, 1);
        clear_flags();
        wr(3'd0, 8'h12);
        send(8'h66, 8, 1'b0, 1'b0, 1'b0);
        check("R13", "irq_err with rx_ie off", {irq_err, irq_rx}, 2'b10);
        clear_flags();
        wr(3'd0, 8'h00);
    endtask

    task automatic t_clk_out();
        int edges;
        logic last;
        wr(3'd0, 8'h20);
        check("R11", "sclk_oe right after write", sclk_oe, 1);
        edges = 0; last = sclk_o;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sclk_o != last) edges++;
            last = sclk_o;
        end
        check("R11", "sclk_o toggles in 200 cycles (12 or 13)", int'(edges >= 12 && edges <= 13), 1);
        wr(3'd0, 8'h00);
        check("R11", "sclk_oe after deselect", sclk_oe, 0);
    endtask

    task automatic t_ext_clk();
        int lows, to;
        wr(3'd2, 8'hFF);
        ext_run = 1'b1;
        wr(3'd0, 8'h40);
        wr(3'd0, 8'h41);
        wr(3'd3, 8'hFF);
        to = 0;
        while (sout !== 1'b0 && to < 3000) begin @(negedge clk); to++; end
        lows = 0;
        while (sout === 1'b0 && lows < 6000) begin @(negedge clk); lows++; end
        check("R12", "start bit length near 96 cycles", int'(lows >= 85 && lows <= 105), 1);
        idle(1200);
        wr(3'd0, 8'h00);
        ext_run = 1'b0;
        wr(3'd2, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        wr(3'd2, 8'h01);
        t_tx_basic();
        t_tx_format();
        t_tx_abort();
        t_rx_basic();
        t_clear_protocol();
        t_false_start();
        t_rx_ignored();
        t_rx_errors();
        t_overrun_and_disable();
        t_irq();
        t_clk_out();
        t_ext_clk();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule